// File: doc/BRIEF.md
# Two-Level Cascaded Priority Interrupt Hub

This block collects 32 interrupt request lines and presents them to a processor as one interrupt line plus a vector. The lines are split over four 8-input slave units. Each slave's summary request enters an 8-input master unit. On the master, input 0 carries a separate auxiliary request. The slaves use master inputs 1, 3, 4 and 5. Inputs 2, 6 and 7 are never driven.

Each of the five units has a byte-wide mask register and a command location that accepts specific end-of-interrupt codes. A 16-bit trigger register, written one byte at a time, switches selected expansion-bus lines between edge and level triggering. Flat IRQ n is expansion IRQ n-7, for n from 7 to 22. An acknowledge pulse moves the current winner into service at both levels. Software then retires the winner by writing an end-of-interrupt code to the slave and then to the master.

Top module: `cascade_irq_hub`

## Requirements
- R1: Reset masks every slave input (slave mask 0xFF, master mask 0x00). It clears all in-service bits, latched edges and the trigger register. With only slave lines requesting, `intOut` is low during reset and after it.
- R2: A write with `regOff`=1 loads the mask of the addressed unit. `regSel` 0..3 selects slaves 0..3 and `regSel` 4 selects the master. A 1 bit masks that input.
- R3: Flat IRQ n sits on slave n>>3 at input n&7. Slaves 0, 1, 2 and 3 drive master inputs 1, 3, 4 and 5. `vecOut` gives the flat index of the winning slave line. When `intOut` is low, `vecOut` and `auxWin` are 0.
- R4: Within a unit, a lower input number has priority. Across slaves, the winner is decided by master input number.
- R5: `intAck` while `intOut` is high sets the in-service bit of the winner in the master and in the owning slave. An input is not presented while an in-service bit at its own or a higher-priority position is set in its unit. A higher-priority input can still preempt.
- R6: A write with `regOff`=0 whose data is 0xE0|n clears in-service bit n of the addressed unit. Any other data at that location has no effect.
- R7: An end-of-interrupt written only to the slave leaves the master input blocked. Both levels need one.
- R8: An edge-mode line latches a request on a rising input. The latch stays set after the input falls and is cleared by the acknowledge. A line held high after that does not request again.
- R9: A level-mode line requests while its input is high. If the input is still high after both end-of-interrupt writes, the line is presented again.
- R10: `regSel` 5 writes the trigger register, with `regOff` choosing byte 0 or byte 1, and a 1 selects level mode. Expansion IRQs 3..7 use byte 0 bits 0..4, IRQs 9..11 use byte 0 bits 5..7, IRQ 12 uses byte 1 bit 0, and IRQs 14..15 use byte 1 bits 1..2.
- R11: Expansion IRQs 0, 1, 2 and 8 (flat 7, 8, 9, 15) are always edge-triggered, whatever the trigger register holds. Flat lines outside the expansion range take a fixed mode from `FIXED_LEVEL`. By default, flat 3 and 6 are edge-triggered and the others are level-triggered.
- R12: The auxiliary input is master input 0 and has the highest priority. When it wins, `auxWin` is 1 and `vecOut` is 0. Once it is acknowledged, nothing is presented until the master end-of-interrupt.
- R13: `intAck` while `intOut` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Flat request lines |
| auxIrq | input | 1 | Auxiliary request on master input 0 (level) |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | 0..3 slave, 4 master, 5 trigger register |
| regOff | input | 1 | 0 command / trigger byte 0, 1 mask / trigger byte 1 |
| regWdata | input | 8 | Write data |
| intAck | input | 1 | Acknowledge pulse: current winner enters service |
| intOut | output | 1 | Interrupt request to processor |
| auxWin | output | 1 | Winner is the auxiliary input |
| vecOut | output | 5 | Flat index of winning slave line |

## Verification
The hardest state to reach from the ports is one where both levels must be retired in order. One case is a slave end-of-interrupt that lands while the master still holds the line in service. Another is a rejected command byte that has to leave the slave blocked after the master is cleared.

The stimulus gets there by keeping a level line high across the acknowledge. It then sends the two end-of-interrupt writes one at a time, or a malformed one first, and checks `intOut` after each write. Preemption is reached the same way. A lower-numbered master input is raised while a later slave is in service.

// File: rtl/cih_pkg.sv
package cih_pkg;
  localparam int LINES     = 8;
  localparam int LW        = $clog2(LINES);
  localparam int SLAVES    = 4;
  localparam int CTLS      = SLAVES + 1;
  localparam int TRIG_SEL  = SLAVES + 1;
  localparam int SW        = $clog2(CTLS + 1);
  localparam int IRQS      = SLAVES * LINES;
  localparam int IW        = $clog2(IRQS);
  localparam int EXP_BASE  = 7;
  localparam int EXP_LINES = 16;
  localparam logic [7-LW:0] EOI_TAG = 5'b11100;

  typedef struct packed {
    logic [CTLS-1:0] maskWr;
    logic [CTLS-1:0] eoiWr;
    logic [LW-1:0]   line;
    logic [7:0]      data;
    logic [1:0]      trigWr;
    logic            ack;
  } cih_stb_t;

  // master input used by each slave
  function automatic int cascadeIn(input int s);
    case (s)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 5;
    endcase
  endfunction

  // trigger-register bit for an expansion IRQ, -1 when fixed
  function automatic int trigBit(input int e);
    if (e >= 3 && e <= 7)   return e - 3;
    if (e >= 9 && e <= 11)  return e - 4;
    if (e == 12)            return 8;
    if (e >= 14 && e <= 15) return e - 5;
    return -1;
  endfunction

  function automatic logic [IRQS-1:0] levelMap(input logic [15:0] ctl,
                                               input logic [IRQS-1:0] fixedLvl);
    logic [IRQS-1:0] r;
    r = fixedLvl;
    for (int e = 0; e < EXP_LINES; e++) begin
      int b;
      b = trigBit(e);
      if (b >= 0) r[e + EXP_BASE] = ctl[b[3:0]];
    end
    return r;
  endfunction
endpackage

// File: rtl/cih_pic_cell.sv
module cih_pic_cell import cih_pkg::*; #(
  parameter logic [LINES-1:0] MASK_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] reqIn,
  input  logic [LINES-1:0] level,
  input  logic             maskWr,
  input  logic [LINES-1:0] maskData,
  input  logic             eoiWr,
  input  logic [LW-1:0]    eoiLine,
  input  logic             ackWr,
  output logic             active,
  output logic [LW-1:0]    winLine
);
  logic [LINES-1:0] mask, isr, latch, prevIn;
  logic [LINES-1:0] rise, req, pend, ackHot, eoiHot;
  logic             found, busy;
  logic [LW-1:0]    isrTop;

  assign rise   = reqIn & ~prevIn;
  assign req    = (level & reqIn) | (~level & latch);
  assign pend   = req & ~mask;
  assign ackHot = ackWr ? (LINES'(1) << winLine) : '0;
  assign eoiHot = eoiWr ? (LINES'(1) << eoiLine) : '0;

  always_comb begin
    found   = 1'b0;
    winLine = '0;
    busy    = 1'b0;
    isrTop  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found   = 1'b1;
        winLine = LW'(i);
      end
      if (isr[i]) begin
        busy   = 1'b1;
        isrTop = LW'(i);
      end
    end
    active = found && (!busy || winLine < isrTop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= MASK_RST;
      isr    <= '0;
      latch  <= '0;
      prevIn <= '0;
    end else begin
      prevIn <= reqIn;
      latch  <= (latch & ~ackHot) | (rise & ~level);
      isr    <= (isr & ~eoiHot) | ackHot;
      if (maskWr) mask <= maskData;
    end
  end
endmodule

// File: rtl/cih_ctrl.sv
module cih_ctrl import cih_pkg::*; (
  input  logic          regWe,
  input  logic [SW-1:0] regSel,
  input  logic          regOff,
  input  logic [7:0]    regWdata,
  input  logic          intAck,
  output cih_stb_t      stb
);
  always_comb begin
    stb      = '0;
    stb.data = regWdata;
    stb.line = regWdata[LW-1:0];
    stb.ack  = intAck;
    if (regWe) begin
      if (int'(regSel) < CTLS) begin
        if (regOff)                          stb.maskWr[regSel] = 1'b1;
        else if (regWdata[7:LW] == EOI_TAG)  stb.eoiWr[regSel]  = 1'b1;
      end else if (int'(regSel) == TRIG_SEL) begin
        stb.trigWr[regOff] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cih_datapath.sv
module cih_datapath import cih_pkg::*; #(
  parameter logic [IRQS-1:0] FIXED_LEVEL = 32'hFF90_0037
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IRQS-1:0] irqIn,
  input  logic            auxIrq,
  input  cih_stb_t        stb,
  output logic            intOut,
  output logic            auxWin,
  output logic [IW-1:0]   vecOut
);
  logic [15:0]       trigCtl;
  logic [IRQS-1:0]   levelAll;
  logic [SLAVES-1:0] slvActive, slvAck;
  logic [LW-1:0]     slvWin [SLAVES];
  logic [LINES-1:0]  masterIn;
  logic              masterActive, ackOk;
  logic [LW-1:0]     masterWin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trigCtl <= '0;
    else begin
      if (stb.trigWr[0]) trigCtl[7:0]  <= stb.data;
      if (stb.trigWr[1]) trigCtl[15:8] <= stb.data;
    end
  end

  assign levelAll = levelMap(trigCtl, FIXED_LEVEL);
  assign ackOk    = stb.ack & masterActive;

  for (genvar s = 0; s < SLAVES; s++) begin : g_slv
    assign slvAck[s] = ackOk && (int'(masterWin) == cascadeIn(s));
    cih_pic_cell #(.MASK_RST('1)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .reqIn(irqIn[s*LINES +: LINES]),
      .level(levelAll[s*LINES +: LINES]),
      .maskWr(stb.maskWr[s]), .maskData(stb.data),
      .eoiWr(stb.eoiWr[s]), .eoiLine(stb.line),
      .ackWr(slvAck[s]),
      .active(slvActive[s]), .winLine(slvWin[s])
    );
  end

  always_comb begin
    masterIn    = '0;
    masterIn[0] = auxIrq;
    for (int s = 0; s < SLAVES; s++) masterIn[cascadeIn(s)] = slvActive[s];
  end

  cih_pic_cell #(.MASK_RST('0)) u_master (
    .clk(clk), .rst_n(rst_n),
    .reqIn(masterIn), .level('1),
    .maskWr(stb.maskWr[SLAVES]), .maskData(stb.data),
    .eoiWr(stb.eoiWr[SLAVES]), .eoiLine(stb.line),
    .ackWr(ackOk),
    .active(masterActive), .winLine(masterWin)
  );

  always_comb begin
    vecOut = '0;
    for (int s = 0; s < SLAVES; s++)
      if (masterActive && int'(masterWin) == cascadeIn(s))
        vecOut = IW'(s * LINES + int'(slvWin[s]));
  end

  assign intOut = masterActive;
  assign auxWin = masterActive && (masterWin == '0);
endmodule

// File: rtl/cascade_irq_hub.sv
module cascade_irq_hub import cih_pkg::*; #(
  parameter logic [IRQS-1:0] FIXED_LEVEL = 32'hFF90_0037
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IRQS-1:0] irqIn,
  input  logic            auxIrq,
  input  logic            regWe,
  input  logic [SW-1:0]   regSel,
  input  logic            regOff,
  input  logic [7:0]      regWdata,
  input  logic            intAck,
  output logic            intOut,
  output logic            auxWin,
  output logic [IW-1:0]   vecOut
);
  cih_stb_t stb;

  cih_ctrl u_ctrl (
    .regWe(regWe), .regSel(regSel), .regOff(regOff),
    .regWdata(regWdata), .intAck(intAck), .stb(stb)
  );

  cih_datapath #(.FIXED_LEVEL(FIXED_LEVEL)) u_dp (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .auxIrq(auxIrq),
    .stb(stb), .intOut(intOut), .auxWin(auxWin), .vecOut(vecOut)
  );
endmodule

// File: rtl/cih_checker.sv
module cih_checker import cih_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          intOut,
  input logic          auxWin,
  input logic [IW-1:0] vecOut,
  input logic          intAck,
  input logic          regWe
);
  // R3
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !intOut |-> vecOut == '0);

  // R12
  idle_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !intOut |-> !auxWin);

  // R5
  rearm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intOut && !auxWin && intAck && !regWe |=>
      !(intOut && !auxWin && vecOut == $past(vecOut)));

  // R12
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intOut && auxWin && intAck && !regWe |=> !intOut);
endmodule

bind cascade_irq_hub cih_checker u_chk (
  .clk(clk), .rst_n(rst_n), .intOut(intOut), .auxWin(auxWin),
  .vecOut(vecOut), .intAck(intAck), .regWe(regWe)
);

// File: tb/test_cascade_irq_hub.sv
`timescale 1ns/1ps
module test_cascade_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irqIn = '0;
  logic        auxIrq = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regOff = 1'b0;
  logic [7:0]  regWdata = '0;
  logic        intAck = 1'b0;
  logic        intOut, auxWin;
  logic [4:0]  vecOut;
  int          nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  cascade_irq_hub i_cascade_irq_hub (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .auxIrq(auxIrq),
    .regWe(regWe), .regSel(regSel), .regOff(regOff), .regWdata(regWdata),
    .intAck(intAck), .intOut(intOut), .auxWin(auxWin), .vecOut(vecOut)
  );

  // op: 0 write, 1 set irqIn, 2 ack, 3 aux level
  // {op[2], sel[3], off, val[32], expInt, expVec[5], req[4]}
  localparam int NV = 46;
  localparam logic [47:0] VEC [NV] = '{
    {2'd1,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd1},  // R1
    {2'd1,3'd0,1'b0,32'h0000_0002,1'b0,5'd0, 4'd1},  // R1 masked
    {2'd0,3'd0,1'b1,32'h0000_0000,1'b1,5'd1, 4'd2},  // R2
    {2'd1,3'd0,1'b0,32'h0000_0003,1'b1,5'd0, 4'd4},  // R4
    {2'd0,3'd0,1'b1,32'h0000_0001,1'b1,5'd1, 4'd2},  // R2
    {2'd2,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd5},  // R5
    {2'd0,3'd0,1'b0,32'h0000_00E1,1'b0,5'd0, 4'd7},  // R7
    {2'd0,3'd4,1'b0,32'h0000_00E1,1'b1,5'd1, 4'd9},  // R9
    {2'd2,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd5},  // R5
    {2'd0,3'd0,1'b0,32'h0000_0041,1'b0,5'd0, 4'd6},  // R6
    {2'd0,3'd4,1'b0,32'h0000_00E1,1'b0,5'd0, 4'd6},  // R6 slave still held
    {2'd0,3'd0,1'b0,32'h0000_00E1,1'b1,5'd1, 4'd6},  // R6
    {2'd1,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd9},  // R9
    {2'd0,3'd1,1'b1,32'h0000_0000,1'b0,5'd0, 4'd2},  // R2
    {2'd1,3'd0,1'b0,32'h0000_1000,1'b1,5'd12,4'd8},  // R8
    {2'd1,3'd0,1'b0,32'h0000_0000,1'b1,5'd12,4'd8},  // R8 latched
    {2'd2,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd8},  // R8
    {2'd0,3'd1,1'b0,32'h0000_00E4,1'b0,5'd0, 4'd7},  // R7
    {2'd0,3'd4,1'b0,32'h0000_00E3,1'b0,5'd0, 4'd8},  // R8 latch cleared
    {2'd1,3'd0,1'b0,32'h0000_1000,1'b1,5'd12,4'd3},  // R3
    {2'd2,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd5},  // R5
    {2'd0,3'd1,1'b0,32'h0000_00E4,1'b0,5'd0, 4'd7},  // R7
    {2'd0,3'd4,1'b0,32'h0000_00E3,1'b0,5'd0, 4'd8},  // R8 held high, no edge
    {2'd0,3'd5,1'b0,32'h0000_0004,1'b1,5'd12,4'd10}, // R10 byte0 bit2
    {2'd0,3'd5,1'b0,32'h0000_0000,1'b0,5'd0, 4'd10}, // R10
    {2'd0,3'd2,1'b1,32'h0000_0000,1'b0,5'd0, 4'd2},  // R2
    {2'd0,3'd5,1'b1,32'h0000_0002,1'b0,5'd0, 4'd10}, // R10 byte1 bit1
    {2'd1,3'd0,1'b0,32'h0020_1000,1'b1,5'd21,4'd10}, // R10
    {2'd1,3'd0,1'b0,32'h0000_1000,1'b0,5'd0, 4'd10}, // R10 level drops
    {2'd1,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd9},  // R9
    {2'd0,3'd5,1'b0,32'h0000_00FF,1'b0,5'd0, 4'd10}, // R10
    {2'd0,3'd5,1'b1,32'h0000_00FF,1'b0,5'd0, 4'd10}, // R10
    {2'd1,3'd0,1'b0,32'h0000_8000,1'b1,5'd15,4'd11}, // R11
    {2'd1,3'd0,1'b0,32'h0000_0000,1'b1,5'd15,4'd11}, // R11 still edge
    {2'd2,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd5},  // R5
    {2'd0,3'd1,1'b0,32'h0000_00E7,1'b0,5'd0, 4'd7},  // R7
    {2'd0,3'd4,1'b0,32'h0000_00E3,1'b0,5'd0, 4'd6},  // R6
    {2'd0,3'd3,1'b1,32'h0000_0000,1'b0,5'd0, 4'd2},  // R2
    {2'd1,3'd0,1'b0,32'h0101_0000,1'b1,5'd16,4'd4},  // R4 across slaves
    {2'd0,3'd4,1'b1,32'h0000_0010,1'b1,5'd24,4'd2},  // R2 master mask
    {2'd0,3'd4,1'b1,32'h0000_0000,1'b1,5'd16,4'd4},  // R4
    {2'd2,3'd0,1'b0,32'h0000_0000,1'b0,5'd0, 4'd5},  // R5 later slave blocked
    {2'd1,3'd0,1'b0,32'h0101_0002,1'b1,5'd1, 4'd5},  // R5 preempt
    {2'd1,3'd0,1'b0,32'h0101_0000,1'b0,5'd0, 4'd5},  // R5
    {2'd0,3'd2,1'b0,32'h0000_00E0,1'b0,5'd0, 4'd7},  // R7
    {2'd0,3'd4,1'b0,32'h0000_00E4,1'b1,5'd16,4'd9}   // R9
  };

  task automatic check(input int req, input bit expInt, input bit expAux,
                       input logic [4:0] expVec);
    nRun++;
    if (intOut !== expInt || auxWin !== expAux || (expInt && vecOut !== expVec)) begin
      nFail++;
      $display("FAIL R%0d: int=%b aux=%b vec=%0d, expected int=%b aux=%b vec=%0d",
               req, intOut, auxWin, vecOut, expInt, expAux, expVec);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [2:0] sel,
                       input logic off, input logic [31:0] val);
    @(negedge clk);
    case (op)
      2'd0: begin regWe = 1'b1; regSel = sel; regOff = off; regWdata = val[7:0]; end
      2'd1: irqIn = val;
      2'd2: intAck = 1'b1;
      default: auxIrq = val[0];
    endcase
    @(posedge clk);
    @(negedge clk);
    regWe  = 1'b0;
    intAck = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1'b0, 5'd0); // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][47:46], VEC[i][45:43], VEC[i][42], VEC[i][41:10]);
      check(int'(VEC[i][3:0]), VEC[i][9], 1'b0, VEC[i][8:4]);
    end

    // R12: auxiliary input beats slave lines, then holds everything
    apply(2'd3, 3'd0, 1'b0, 32'h1);
    check(12, 1'b1, 1'b1, 5'd0);
    apply(2'd2, 3'd0, 1'b0, 32'h0);
    check(12, 1'b0, 1'b0, 5'd0);
    apply(2'd0, 3'd4, 1'b0, 32'hE0);
    check(12, 1'b1, 1'b1, 5'd0);
    apply(2'd3, 3'd0, 1'b0, 32'h0);
    check(12, 1'b1, 1'b0, 5'd16);

    // R13: acknowledge with nothing pending must not block later lines
    apply(2'd1, 3'd0, 1'b0, 32'h0);
    check(13, 1'b0, 1'b0, 5'd0);
    apply(2'd2, 3'd0, 1'b0, 32'h0);
    apply(2'd1, 3'd0, 1'b0, 32'h2);
    check(13, 1'b1, 1'b0, 5'd1);

    // R1: reset mid-run re-masks slave lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 1'b0, 5'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1, 1'b0, 1'b0, 5'd0);
    apply(2'd0, 3'd0, 1'b1, 32'h0);
    check(1, 1'b1, 1'b0, 5'd1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule